// File: doc/BRIEF.md
# Status-Flag Arithmetic Logic Unit

This block is the execution stage arithmetic unit of a small processor core. It takes two register operands and an operation code and returns a result in the same cycle, together with a strobe that says whether the result should be written back to the register file. Operand fetch, decode and the register file are outside it. The operand width is set by the `WIDTH` parameter.

Alongside the combinational result the block keeps a four-bit status register: zero, negative, carry and overflow. This register is written on the rising clock edge only when the flag-enable input is high. The carry-in operations read it, so a chain of word-by-word operations can build arithmetic and comparisons wider than one register. Compare operations set the flags and never request a write-back. In every subtraction the carry flag means "a borrow occurred".

Top module: `flag_alu`

## Requirements
- R1: Operation code 0 (add) gives result = (opA + opB) mod 2^WIDTH. The carry flag becomes the carry out of the top bit. The overflow flag is set when the signed sum does not fit in WIDTH bits.
- R2: Operation code 1 (add with carry) gives result = (opA + opB + flagC) mod 2^WIDTH. Carry and overflow follow the rules of R1.
- R3: Operation code 2 (subtract) gives result = (opA - opB) mod 2^WIDTH. The carry flag is set exactly when opA < opB as unsigned numbers (a borrow). The overflow flag is set when the signed difference does not fit.
- R4: Operation code 3 (subtract with borrow) gives result = (opA - opB - flagC) mod 2^WIDTH. The carry flag is set when a borrow out of the top bit occurs. The overflow flag is set when the signed difference does not fit.
- R5: Operation codes 4 (compare) and 5 (compare with borrow) update all four flags exactly as codes 2 and 3 do, and hold resultWe low. A compare of the low words followed by a compare with borrow of the high words leaves flagC set exactly when the wide value opA is below opB.
- R6: For every defined operation, an enabled update sets flagZ when the result is all zeros and sets flagN to the result's top bit.
- R7: Operation codes 6 (AND), 7 (OR), 8 (XOR) and 9 (NOT of opA, opB ignored) give the bitwise result. An enabled update clears flagC and flagV.
- R8: Operation code 10 (negate) gives result = (0 - opA) mod 2^WIDTH. flagC is set when opA is nonzero. flagV is set when opA is the most negative value.
- R9: The flags change only on a rising clock edge with flagEn high. With flagEn low they hold, while result still follows the inputs.
- R10: An active-low asynchronous reset clears all four flags.
- R11: Operation codes 11 to 15 are undefined. They hold resultWe low and leave the flags unchanged even with flagEn high.
- R12: resultWe is high for operation codes 0 to 3 and 6 to 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the flags update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| opSel | input | 4 | Operation code |
| opA | input | WIDTH | First operand (sole operand of NOT and negate) |
| opB | input | WIDTH | Second operand |
| flagEn | input | 1 | Allows the flag register to load on this edge |
| result | output | WIDTH | Combinational result |
| resultWe | output | 1 | Result should be written back |
| flagZ | output | 1 | Zero flag |
| flagN | output | 1 | Negative flag |
| flagC | output | 1 | Carry / borrow flag |
| flagV | output | 1 | Signed overflow flag |

## Verification
The clocked properties assume that opSel, opA, opB and flagEn carry known values at every rising edge after reset is released. They also assume that reset is asserted before the first meaningful edge, so the flag register starts from a defined state. The bench meets both conditions. It drives every input from a defined value at time zero, holds reset through the first edges, and changes stimulus only on falling edges. The carry-in that a vector needs is loaded by an explicit add through the normal interface, never by reaching into the flag register.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBC = 4'd3,
    OP_CMP  = 4'd4,
    OP_CMPC = 4'd5,
    OP_AND  = 4'd6,
    OP_OR   = 4'd7,
    OP_XOR  = 4'd8,
    OP_NOT  = 4'd9,
    OP_NEG  = 4'd10
  } alu_op_e;

  // carry-in source for the adder
  typedef enum logic [1:0] {
    CIN_ZERO  = 2'd0,
    CIN_ONE   = 2'd1,
    CIN_FLAG  = 2'd2,
    CIN_NFLAG = 2'd3
  } cin_sel_e;

  typedef enum logic [1:0] {
    LOG_AND = 2'd0,
    LOG_OR  = 2'd1,
    LOG_XOR = 2'd2,
    LOG_NOT = 2'd3
  } log_sel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     valid;     // defined operation, flags may load
    logic     arith;     // adder result selected, C/V live
    logic     negate;    // x = 0, y = opA
    logic     invY;      // invert the y operand
    cin_sel_e cinSel;
    logic     borrow;    // carry flag reports borrow
    log_sel_e logSel;
    logic     writeRes;
  } alu_strobe_t;

  typedef struct packed {
    logic z;
    logic n;
    logic c;
    logic v;
  } alu_flags_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [3:0]  opSel,
  output alu_strobe_t strobe
);

  always_comb begin
    strobe = '0;
    unique case (opSel)
      OP_ADD: begin
        strobe.valid = 1'b1; strobe.arith = 1'b1;
        strobe.cinSel = CIN_ZERO; strobe.writeRes = 1'b1;
      end
      OP_ADDC: begin
        strobe.valid = 1'b1; strobe.arith = 1'b1;
        strobe.cinSel = CIN_FLAG; strobe.writeRes = 1'b1;
      end
      OP_SUB, OP_CMP: begin
        strobe.valid = 1'b1; strobe.arith = 1'b1;
        strobe.invY = 1'b1; strobe.borrow = 1'b1;
        strobe.cinSel = CIN_ONE;
        strobe.writeRes = (opSel == OP_SUB);
      end
      OP_SUBC, OP_CMPC: begin
        strobe.valid = 1'b1; strobe.arith = 1'b1;
        strobe.invY = 1'b1; strobe.borrow = 1'b1;
        strobe.cinSel = CIN_NFLAG;
        strobe.writeRes = (opSel == OP_SUBC);
      end
      OP_AND: begin
        strobe.valid = 1'b1; strobe.logSel = LOG_AND; strobe.writeRes = 1'b1;
      end
      OP_OR: begin
        strobe.valid = 1'b1; strobe.logSel = LOG_OR; strobe.writeRes = 1'b1;
      end
      OP_XOR: begin
        strobe.valid = 1'b1; strobe.logSel = LOG_XOR; strobe.writeRes = 1'b1;
      end
      OP_NOT: begin
        strobe.valid = 1'b1; strobe.logSel = LOG_NOT; strobe.writeRes = 1'b1;
      end
      OP_NEG: begin
        strobe.valid = 1'b1; strobe.arith = 1'b1; strobe.negate = 1'b1;
        strobe.invY = 1'b1; strobe.borrow = 1'b1;
        strobe.cinSel = CIN_ONE; strobe.writeRes = 1'b1;
      end
      default: strobe = '0;  // undefined codes: no write, no flag load
    endcase
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             flagEn,
  input  alu_strobe_t      strobe,
  output logic [WIDTH-1:0] result,
  output alu_flags_t       flagsQ
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] xOp;
  logic [WIDTH-1:0] yRaw;
  logic [WIDTH-1:0] yOp;
  logic             cinBit;
  logic [WIDTH:0]   sumWide;
  logic [WIDTH-1:0] arithRes;
  logic [WIDTH-1:0] logicRes;
  logic             carryOut;
  logic             cNext;
  logic             vNext;
  alu_flags_t       flagsD;

  // adder operand selection
  always_comb begin
    xOp  = strobe.negate ? '0  : opA;
    yRaw = strobe.negate ? opA : opB;
    yOp  = strobe.invY ? ~yRaw : yRaw;
    unique case (strobe.cinSel)
      CIN_ZERO:  cinBit = 1'b0;
      CIN_ONE:   cinBit = 1'b1;
      CIN_FLAG:  cinBit = flagsQ.c;
      CIN_NFLAG: cinBit = ~flagsQ.c;
      default:   cinBit = 1'b0;
    endcase
  end

  always_comb begin
    sumWide  = {1'b0, xOp} + {1'b0, yOp} + (WIDTH+1)'(cinBit);
    arithRes = sumWide[WIDTH-1:0];
    carryOut = sumWide[WIDTH];
    cNext    = strobe.borrow ? ~carryOut : carryOut;
    vNext    = (xOp[MSB] == yOp[MSB]) && (arithRes[MSB] != xOp[MSB]);
  end

  always_comb begin
    unique case (strobe.logSel)
      LOG_AND: logicRes = opA & opB;
      LOG_OR:  logicRes = opA | opB;
      LOG_XOR: logicRes = opA ^ opB;
      LOG_NOT: logicRes = ~opA;
      default: logicRes = '0;
    endcase
  end

  always_comb begin
    result   = strobe.arith ? arithRes : logicRes;
    flagsD.z = (result == '0);
    flagsD.n = result[MSB];
    flagsD.c = strobe.arith ? cNext : 1'b0;
    flagsD.v = strobe.arith ? vNext : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flagsQ <= '0;
    end else if (flagEn && strobe.valid) begin
      flagsQ <= flagsD;
    end
  end

  // R9: flags hold while the enable is low
  a_r9_hold_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !flagEn |=> $stable(flagsQ));

  // R6: zero flag follows the result that was on the output at the load edge
  a_r6_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (flagEn && strobe.valid) |=> (flagsQ.z == ($past(result) == '0)));

  // R6: negative flag follows the result sign
  a_r6_neg_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (flagEn && strobe.valid) |=> (flagsQ.n == $past(result[MSB])));

  // R7: logical operations leave carry and overflow clear
  a_r7_logic_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (flagEn && strobe.valid && !strobe.arith) |=> (!flagsQ.c && !flagsQ.v));

  // R11: an invalid code never loads the flags
  a_r11_invalid_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.valid) |=> $stable(flagsQ));

endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       opSel,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             flagEn,
  output logic [WIDTH-1:0] result,
  output logic             resultWe,
  output logic             flagZ,
  output logic             flagN,
  output logic             flagC,
  output logic             flagV
);

  alu_strobe_t strobe;
  alu_flags_t  flagsQ;

  alu_ctrl u_ctrl (
    .opSel  (opSel),
    .strobe (strobe)
  );

  alu_datapath #(.WIDTH(WIDTH)) u_datapath (
    .clk    (clk),
    .rst_n  (rst_n),
    .opA    (opA),
    .opB    (opB),
    .flagEn (flagEn),
    .strobe (strobe),
    .result (result),
    .flagsQ (flagsQ)
  );

  assign resultWe = strobe.writeRes;
  assign flagZ    = flagsQ.z;
  assign flagN    = flagsQ.n;
  assign flagC    = flagsQ.c;
  assign flagV    = flagsQ.v;

  // R5: compares never request write-back
  a_r5_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (opSel == OP_CMP || opSel == OP_CMPC) |-> !resultWe);

  // R11: undefined codes never request write-back
  a_r11_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (opSel > OP_NEG) |-> !resultWe);

  // R3: plain subtract reports a borrow exactly when opA < opB unsigned
  a_r3_borrow: assert property (@(posedge clk) disable iff (!rst_n)
    (flagEn && opSel == OP_SUB) |=> (flagC == ($past(opA) < $past(opB))));

endmodule

// File: tb/flag_alu_bench.sv
`timescale 1ns/1ps
module flag_alu_bench;

  localparam int W = 8;

  typedef struct packed {
    logic [3:0] op;
    logic [7:0] a;
    logic [7:0] b;
    logic       cin;
    logic [7:0] res;
    logic       we;
    logic [3:0] zncv;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{4'd0,  8'h12, 8'h34, 1'b0, 8'h46, 1'b1, 4'b0000, 8'd1},  // R1 plain add
    '{4'd0,  8'h7F, 8'h01, 1'b0, 8'h80, 1'b1, 4'b0101, 8'd1},  // R1 signed overflow
    '{4'd0,  8'hFF, 8'h01, 1'b0, 8'h00, 1'b1, 4'b1010, 8'd1},  // R1 carry out, zero
    '{4'd1,  8'h10, 8'h20, 1'b1, 8'h31, 1'b1, 4'b0000, 8'd2},  // R2 carry in
    '{4'd1,  8'hFF, 8'h00, 1'b1, 8'h00, 1'b1, 4'b1010, 8'd2},  // R2 carry ripple
    '{4'd2,  8'h50, 8'h20, 1'b0, 8'h30, 1'b1, 4'b0000, 8'd3},  // R3 no borrow
    '{4'd2,  8'h20, 8'h50, 1'b0, 8'hD0, 1'b1, 4'b0110, 8'd3},  // R3 borrow
    '{4'd2,  8'h80, 8'h01, 1'b0, 8'h7F, 1'b1, 4'b0001, 8'd3},  // R3 overflow
    '{4'd3,  8'h50, 8'h20, 1'b1, 8'h2F, 1'b1, 4'b0000, 8'd4},  // R4 borrow in
    '{4'd3,  8'h00, 8'h00, 1'b1, 8'hFF, 1'b1, 4'b0110, 8'd4},  // R4 borrow through
    '{4'd4,  8'h33, 8'h33, 1'b1, 8'h00, 1'b0, 4'b1000, 8'd5},  // R5 compare equal
    '{4'd5,  8'h10, 8'h10, 1'b1, 8'hFF, 1'b0, 4'b0110, 8'd5},  // R5 compare w/ borrow
    '{4'd6,  8'hF0, 8'h3C, 1'b1, 8'h30, 1'b1, 4'b0000, 8'd7},  // R7 AND clears C
    '{4'd7,  8'h0F, 8'h80, 1'b1, 8'h8F, 1'b1, 4'b0100, 8'd7},  // R7 OR, R6 negative
    '{4'd8,  8'hAA, 8'hAA, 1'b1, 8'h00, 1'b1, 4'b1000, 8'd7},  // R7 XOR, R6 zero
    '{4'd9,  8'h0F, 8'h55, 1'b1, 8'hF0, 1'b1, 4'b0100, 8'd7},  // R7 NOT ignores opB
    '{4'd10, 8'h01, 8'h00, 1'b0, 8'hFF, 1'b1, 4'b0110, 8'd8},  // R8 negate one
    '{4'd10, 8'h00, 8'h00, 1'b1, 8'h00, 1'b1, 4'b1000, 8'd8},  // R8 negate zero
    '{4'd10, 8'h80, 8'h00, 1'b0, 8'h80, 1'b1, 4'b0111, 8'd8}   // R8 most negative
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [3:0]   opSel = '0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic         flagEn = 1'b0;
  logic [W-1:0] result;
  logic         resultWe;
  logic         flagZ, flagN, flagC, flagV;

  int nChecks = 0;
  int nFail = 0;

  always #4 clk = ~clk;  // 125 MHz

  flag_alu #(.WIDTH(W)) u_flag_alu (
    .clk(clk), .rst_n(rst_n), .opSel(opSel), .opA(opA), .opB(opB),
    .flagEn(flagEn), .result(result), .resultWe(resultWe),
    .flagZ(flagZ), .flagN(flagN), .flagC(flagC), .flagV(flagV)
  );

  function automatic logic [3:0] flagsNow();
    return {flagZ, flagN, flagC, flagV};
  endfunction

  task automatic check(input int req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // drive an operation at a falling edge; caller waits for the load edge
  task automatic drive(input logic [3:0] op, input logic [7:0] a,
                       input logic [7:0] b, input logic en);
    @(negedge clk);
    opSel = op; opA = a; opB = b; flagEn = en;
  endtask

  // load the carry flag through a plain add (R1)
  task automatic presetCarry(input logic c);
    drive(4'd0, c ? 8'hFF : 8'h00, c ? 8'h01 : 8'h00, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    check(10, "flags in reset", 16'(flagsNow()), 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(10, "flags after release", 16'(flagsNow()), 16'h0);

    // table walk: R1..R8, R12
    for (int i = 0; i < NV; i++) begin
      presetCarry(VECS[i].cin);
      drive(VECS[i].op, VECS[i].a, VECS[i].b, 1'b1);
      #1;
      check(int'(VECS[i].req), $sformatf("vec %0d result", i),
            16'(result), 16'(VECS[i].res));
      check(12, $sformatf("vec %0d resultWe", i),
            16'(resultWe), 16'(VECS[i].we));
      @(negedge clk);
      flagEn = 1'b0;
      check(int'(VECS[i].req), $sformatf("vec %0d flags ZNCV", i),
            16'(flagsNow()), 16'(VECS[i].zncv));
    end

    // R9: flags hold with enable low, result still live
    presetCarry(1'b1);                       // flags -> Z=1 C=1
    drive(4'd2, 8'h20, 8'h50, 1'b0);
    #1;
    check(9, "result with enable low", 16'(result), 16'hD0);
    @(negedge clk);
    check(9, "flags held", 16'(flagsNow()), 16'b1010);

    // R11: undefined code
    drive(4'd13, 8'h05, 8'h05, 1'b1);
    #1;
    check(11, "undefined resultWe", 16'(resultWe), 16'h0);
    @(negedge clk);
    check(11, "undefined flags held", 16'(flagsNow()), 16'b1010);

    // R5: two-word compares, 0x1234 vs 0x1235 (below)
    drive(4'd4, 8'h34, 8'h35, 1'b1);
    drive(4'd5, 8'h12, 8'h12, 1'b1);
    #1;
    check(5, "wide cmp resultWe", 16'(resultWe), 16'h0);
    @(negedge clk);
    check(5, "wide below C", 16'(flagC), 16'h1);
    // 0x1234 vs 0x1234 (equal)
    drive(4'd4, 8'h34, 8'h34, 1'b1);
    drive(4'd5, 8'h12, 8'h12, 1'b1);
    @(negedge clk);
    check(5, "wide equal Z,C", 16'({flagZ, flagC}), 16'b10);
    // 0x1300 vs 0x12FF (above)
    drive(4'd4, 8'h00, 8'hFF, 1'b1);
    drive(4'd5, 8'h13, 8'h12, 1'b1);
    @(negedge clk);
    check(5, "wide above C", 16'(flagC), 16'h0);
    flagEn = 1'b0;

    // R10: asynchronous reset in mid-run
    presetCarry(1'b1);
    @(negedge clk);
    flagEn = 1'b0;
    rst_n = 1'b0;
    #1;
    check(10, "async reset clears", 16'(flagsNow()), 16'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule